// File: doc/BRIEF.md
# SONET Loss-of-Signal Monitor

This block watches a received byte stream from a SONET line for loss of signal. Each byte is checked before any descrambling takes place, so turning a downstream descrambler on or off does not change what the monitor sees. The monitor counts runs of consecutive all-zero bytes. When a run reaches a programmable 16-bit threshold, the defect is declared. While the defect is declared, a run of bytes that contain at least one set bit, reaching the same threshold, clears it.

The threshold is held in two 8-bit read/write registers, one for the high byte and one for the low byte. For standards-compliant behaviour the threshold is set between 0x000F and 0x0288 inclusive. That range keeps a zero burst of 2.3 µs or less from being declared and ensures one of 100 µs or more is declared. The defect state appears in bit 0 of a status byte. A one-cycle event pulse marks every declare or clear transition so that an external interrupt block can pick it up.

The input is a valid/ready stream. The monitor never applies back-pressure: `in_ready` is held high, and a byte is taken on every rising clock edge where `in_valid` is high. Cycles where `in_valid` is low are idle. During an idle cycle the run counts are neither advanced nor reset.

Top module: `sonet_los_monitor`

## Requirements
- R1: After reset both threshold registers read 0x01, so the threshold is 0x0101. The status byte reads 0x00, `los_event` is 0 and both run counts are zero.
- R2: When `reg_wr` is high at a clock edge, `reg_wdata` is written to the register chosen by `reg_sel`. A value of 0 selects the low byte (threshold bits 7:0) and 1 selects the high byte (bits 15:8). `reg_rdata` always shows the selected register.
- R3: While the defect is clear, the defect is declared at the clock edge that accepts the N-th consecutive zero byte, where N is the threshold. A threshold of 0 behaves as 1. Status bit 0 reads 1 from the next cycle on.
- R4: An accepted byte that is not zero restarts the run of zero bytes from zero.
- R5: While the defect is declared, it clears at the edge that accepts the N-th consecutive non-zero byte, and status bit 0 returns to 0. An accepted zero byte restarts the non-zero run.
- R6: `los_event` is high for exactly the one cycle in which status bit 0 has just changed, and is low otherwise.
- R7: An idle cycle (`in_valid` low) leaves both run counts and the status unchanged.
- R8: The run counters saturate at 0xFFFF instead of wrapping. A threshold of 0xFFFF declares on the 65535th zero byte and not earlier.
- R9: `in_ready` is always 1.
- R10: Status bits 7:1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Always 1; the monitor never stalls |
| in_data | input | 8 | Received byte, taken before descrambling |
| reg_wr | input | 1 | Write strobe for the threshold registers |
| reg_sel | input | 1 | 0 selects the low threshold byte, 1 selects the high byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Contents of the selected register |
| los_status | output | 8 | Bit 0 is the defect flag; bits 7:1 are zero |
| los_event | output | 1 | One-cycle pulse on each declare or clear |

## Verification
The bench builds the block with its default parameters: a 16-bit threshold split into two 8-bit registers. Programming small thresholds from 0 to 5 makes an exhaustive sweep feasible. Every zero/non-zero pattern of eight bytes, with idle gaps mixed in, is run against each of these thresholds, which covers every run length just below, at and above each threshold for both declaring and clearing. The reset threshold of 257 and the full-scale threshold of 0xFFFF are each run once to their exact boundary.

// File: rtl/los_pkg.sv
package los_pkg;

  typedef enum logic {
    ST_CLEAR    = 1'b0,
    ST_DECLARED = 1'b1
  } los_state_e;

  localparam logic [7:0] THR_BYTE_RST = 8'h01;

endpackage

// File: rtl/los_thr_regs.sv
module los_thr_regs #(
  parameter int REG_W = 8,
  parameter int NREG  = 2,
  parameter int SEL_W = 1,
  parameter logic [REG_W-1:0] RST_VAL = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        sel,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W-1:0]        rdata,
  output logic [NREG*REG_W-1:0]   thr
);

  logic [REG_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= RST_VAL;
      end else if (wr_en && (sel == SEL_W'(g))) begin
        regs_q[g] <= wdata;
      end
    end
    assign thr[g*REG_W +: REG_W] = regs_q[g];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel == SEL_W'(i)) rdata = regs_q[i];
    end
  end

endmodule

// File: rtl/los_run_counter.sv
module los_run_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         hit,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);

  localparam logic [W-1:0] CNT_MAX = '1;

  always_comb begin
    cnt_nxt = cnt_q;
    if (take) begin
      if (!hit)                cnt_nxt = '0;
      else if (cnt_q != CNT_MAX) cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/los_state.sv
module los_state
  import los_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         is_zero,
  input  logic [W-1:0] zero_nxt,
  input  logic [W-1:0] ones_nxt,
  input  logic [W-1:0] thr,
  output logic         defect,
  output logic         change
);

  los_state_e state_q, state_d;
  logic [W-1:0] thr_eff;

  assign thr_eff = (thr == '0) ? W'(1) : thr;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CLEAR:
        if (take && is_zero && (zero_nxt >= thr_eff)) state_d = ST_DECLARED;
      ST_DECLARED:
        if (take && !is_zero && (ones_nxt >= thr_eff)) state_d = ST_CLEAR;
      default: state_d = ST_CLEAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CLEAR;
      change  <= 1'b0;
    end else begin
      state_q <= state_d;
      change  <= (state_d != state_q);
    end
  end

  assign defect = (state_q == ST_DECLARED);

endmodule

// File: rtl/sonet_los_monitor.sv
module sonet_los_monitor
  import los_pkg::*;
#(
  parameter int THR_W  = 16,
  parameter int REG_W  = 8,
  parameter int DATA_W = 8,
  localparam int NREG  = THR_W / REG_W,
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [REG_W-1:0]  los_status,
  output logic              los_event
);

  logic [THR_W-1:0] thr;
  logic [THR_W-1:0] zero_cnt, zero_nxt;
  logic [THR_W-1:0] ones_cnt, ones_nxt;
  logic             take, is_zero, defect;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;
  assign is_zero  = (in_data == '0);

  los_thr_regs #(
    .REG_W  (REG_W),
    .NREG   (NREG),
    .SEL_W  (SEL_W),
    .RST_VAL(REG_W'(THR_BYTE_RST))
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(reg_wr),
    .sel  (reg_sel),
    .wdata(reg_wdata),
    .rdata(reg_rdata),
    .thr  (thr)
  );

  los_run_counter #(.W(THR_W)) u_zero_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .hit    (is_zero),
    .cnt_q  (zero_cnt),
    .cnt_nxt(zero_nxt)
  );

  los_run_counter #(.W(THR_W)) u_ones_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .hit    (!is_zero),
    .cnt_q  (ones_cnt),
    .cnt_nxt(ones_nxt)
  );

  los_state #(.W(THR_W)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .is_zero (is_zero),
    .zero_nxt(zero_nxt),
    .ones_nxt(ones_nxt),
    .thr     (thr),
    .defect  (defect),
    .change  (los_event)
  );

  assign los_status = {{(REG_W-1){1'b0}}, defect};

endmodule

// File: rtl/sonet_los_monitor_chk.sv
module sonet_los_monitor_chk #(
  parameter int THR_W  = 16,
  parameter int REG_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [REG_W-1:0]  los_status,
  input logic              los_event,
  input logic [THR_W-1:0]  zero_cnt,
  input logic [THR_W-1:0]  ones_cnt
);

  localparam logic [THR_W-1:0] CNT_MAX = '1;

  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  p_high_bits_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    los_status[REG_W-1:1] == '0);

  p_declare_on_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_status[0]) |-> $past(in_valid && (in_data == '0)));

  p_clear_on_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_status[0]) |-> $past(in_valid && (in_data != '0)));

  p_event_only_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    los_event |-> (los_status[0] != $past(los_status[0])));

  p_change_gives_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (los_status[0] != $past(los_status[0])) |-> los_event);

  p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(zero_cnt) && $stable(ones_cnt) && $stable(los_status)));

  p_nonzero_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_data != '0)) |=> (zero_cnt == '0));

  p_zero_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_data == '0) && (zero_cnt == CNT_MAX)) |=> (zero_cnt == CNT_MAX));

endmodule

bind sonet_los_monitor sonet_los_monitor_chk #(
  .THR_W (THR_W),
  .REG_W (REG_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .los_status(los_status),
  .los_event (los_event),
  .zero_cnt  (zero_cnt),
  .ones_cnt  (ones_cnt)
);

// File: tb/sonet_los_monitor_tb.sv
module sonet_los_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       reg_wr = 1'b0;
  logic [0:0] reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] los_status;
  logic       los_event;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int  m_thr  = 257;
  int  m_zero = 0;
  int  m_ones = 0;
  bit  m_los  = 1'b0;
  string tag_ovr = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  sonet_los_monitor u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .los_status(los_status),
    .los_event (los_event)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one byte at the current falling edge; return at the next falling edge.
  task automatic put(input logic [7:0] b);
    bit prev;
    int eff;
    string tag;
    in_valid = 1'b1;
    in_data  = b;
    prev = m_los;
    eff  = (m_thr == 0) ? 1 : m_thr;
    if (b == 8'h00) begin
      if (m_zero < 65535) m_zero++;
      m_ones = 0;
      if (!m_los && m_zero >= eff) m_los = 1'b1;
    end else begin
      if (m_ones < 65535) m_ones++;
      m_zero = 0;
      if (m_los && m_ones >= eff) m_los = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (tag_ovr != "")      tag = tag_ovr;
    else if (b == 8'h00)    tag = "R3";
    else if (prev)          tag = "R5";
    else                    tag = "R4";
    check(tag, los_status, {7'b0, m_los});
    check("R6", los_event, (m_los != prev));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R7", los_status, {7'b0, m_los});
      check("R7", los_event, 0);
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    reg_wr = 1'b1;
    reg_sel = sel;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_thr(input int t);
    wr(1'b1, t[15:8]);
    wr(1'b0, t[7:0]);
    m_thr = t;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R9 ready
    reg_sel = 1'b0; #1;
    check("R1", reg_rdata, 8'h01);
    reg_sel = 1'b1; #1;
    check("R1", reg_rdata, 8'h01);
    check("R1", los_status, 8'h00);
    check("R1", los_event, 0);
    check("R9", in_ready, 1);
    @(negedge clk);

    // R1 reset threshold 0x0101: declares on the 257th zero byte
    for (int i = 0; i < 257; i++) put(8'h00);
    check("R1", los_status, 8'h01);
    for (int i = 0; i < 257; i++) put(8'h5A);
    check("R1", los_status, 8'h00);

    // R2 register write / readback, high byte at select 1
    wr(1'b1, 8'hA5);
    wr(1'b0, 8'h3C);
    reg_sel = 1'b1; #1;
    check("R2", reg_rdata, 8'hA5);
    reg_sel = 1'b0; #1;
    check("R2", reg_rdata, 8'h3C);
    @(negedge clk);

    // Exhaustive 8-byte zero/non-zero patterns against thresholds 0..5
    for (int t = 0; t <= 5; t++) begin
      set_thr(t);
      for (int p = 0; p < 256; p++) begin
        for (int b = 0; b < 8; b++) begin
          if (p[b]) put(8'h01 << ((p + b) % 8));
          else      put(8'h00);
          if (((p >> b) & 3) == 3) idle(1);
        end
      end
    end

    // R10 and R9 after the sweep
    check("R10", los_status & 8'hFE, 0);
    check("R9", in_ready, 1);

    // R8 full-scale threshold
    set_thr(16'hFFFF);
    tag_ovr = "R8";
    put(8'h77);
    for (int i = 0; i < 65535; i++) put(8'h00);
    check("R8", los_status, 8'h01);
    put(8'h00);
    put(8'h00);
    check("R8", los_status, 8'h01);
    tag_ovr = "";
    set_thr(1);
    put(8'h80);
    check("R5", los_status, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule